// File: doc/BRIEF.md
# Register Read Decoder with Multiplexed Internal Address

This block sits between the address sources of a console processor and its on-chip sound and controller registers. Three sources can place an address on the internal bus: the processor core, a sprite-copy DMA engine and a sample-fetch DMA engine. A small multiplexer picks one of them from the grant inputs. On every read cycle the block then decides three things. It decides whether an on-chip register answers the read. It decides whether one of the two controller ports receives a clock pulse. It decides whether the internal data bus is cut off from the external data bus.

The range check and the select are taken from different places. The register window is tested on the core's own address. The five select bits are taken from the multiplexed address. As a result, a DMA read can hit a register, or clock a controller, whenever the core happens to be parked inside the window. When the data bus is isolated, the register value replaces the data the DMA would normally fetch. The external open-bus latch keeps its old value through an isolated read. A controller select without isolation lets the external data through and raises a conflict flag.

Top module: `brd_read_decoder`

## Requirements
- R1: The internal address and read request come from the sample DMA when `smp_grant` is 1. Otherwise they come from the sprite DMA when `spr_grant` is 1. Otherwise they come from the core.
- R2: A register access is possible only when core address bits [15:5] equal those of 0x4000, so the core address lies in 0x4000–0x401F. Outside that range, no strobe or isolation occurs and `int_data` equals `ext_data`. The boundary cases are 0x401F (inside) and 0x4020 (outside).
- R3: The register select is bits [4:0] of the multiplexed internal address, not of the core address.
- R4: On a read in the window, select 0x16 drives `pad_clk0` high and select 0x17 drives `pad_clk1` high, in the same cycle only. The two strobes are never high together.
- R5: Select 0x15 on a read in the window sets `isolate` to 1, and `int_data` then equals `status_data`.
- R6: With `test_pin` high, every read in the window is isolated. Select 0x15 still returns `status_data`; any other select returns 0x00.
- R7: `openbus_q` resets to 0x00. On each clock edge of a non-isolated read cycle it loads `ext_data`, and it holds its value when there is no read.
- R8: An isolated read leaves `openbus_q` unchanged.
- R9: A controller select without isolation sets `conflict` to 1 and passes `ext_data` to `int_data`. With `test_pin` high, the strobe still fires but `conflict` is 0.
- R10: A DMA read while the core address lies in the window performs the register read that its select bits name, overriding the DMA data.
- R11: With no read request from the selected source, there is no strobe and no isolation, and `int_data` equals `ext_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_addr | input | 16 | Core address, also used for the window check |
| core_rd | input | 1 | Core read request |
| spr_addr | input | 16 | Sprite DMA address |
| spr_rd | input | 1 | Sprite DMA read request |
| spr_grant | input | 1 | Sprite DMA owns the bus |
| smp_addr | input | 16 | Sample DMA address |
| smp_rd | input | 1 | Sample DMA read request |
| smp_grant | input | 1 | Sample DMA owns the bus (highest priority) |
| test_pin | input | 1 | Test mode: isolate every read in the window |
| ext_data | input | 8 | External data bus value |
| status_data | input | 8 | Value of the readable status register |
| int_data | output | 8 | Internal read data |
| pad_clk0 | output | 1 | First controller clock strobe |
| pad_clk1 | output | 1 | Second controller clock strobe |
| isolate | output | 1 | Internal bus cut off from external bus |
| conflict | output | 1 | Controller strobe while external data drives the bus |
| openbus_q | output | 8 | External open-bus latch |

## Verification
The assertions assume that every input is a known level, held for a whole cycle. They also assume that a read request counts only for the source that owns the bus, so a request from a source without the grant has no effect. The latch assertions compare `openbus_q` against the data of the previous cycle, so they rely on the inputs changing only away from the rising edge. The bench meets this by driving all inputs just after each rising edge, or at a falling edge. It then reads the combinational outputs before the next rising edge.

// File: rtl/brd_pkg.sv
package brd_pkg;
   typedef enum logic [1:0] {
      SRC_CORE   = 2'd0,
      SRC_SPRITE = 2'd1,
      SRC_SAMPLE = 2'd2
   } src_t;
endpackage

// File: rtl/brd_addr_mux.sv
// Internal address multiplexer: one of three sources owns the bus per cycle.
module brd_addr_mux #(
   parameter int AW           = 16,
   parameter bit SAMPLE_FIRST = 1'b1
) (
   input  logic [AW-1:0]    core_addr,
   input  logic             core_rd,
   input  logic [AW-1:0]    spr_addr,
   input  logic             spr_rd,
   input  logic             spr_grant,
   input  logic [AW-1:0]    smp_addr,
   input  logic             smp_rd,
   input  logic             smp_grant,
   output logic [AW-1:0]    bus_addr,
   output logic             bus_rd,
   output brd_pkg::src_t    bus_src
);
   import brd_pkg::*;

   generate
      if (SAMPLE_FIRST) begin : g_sample_first
         always_comb begin
            if (smp_grant) begin
               bus_addr = smp_addr;
               bus_rd   = smp_rd;
               bus_src  = SRC_SAMPLE;
            end else if (spr_grant) begin
               bus_addr = spr_addr;
               bus_rd   = spr_rd;
               bus_src  = SRC_SPRITE;
            end else begin
               bus_addr = core_addr;
               bus_rd   = core_rd;
               bus_src  = SRC_CORE;
            end
         end
      end else begin : g_sprite_first
         always_comb begin
            if (spr_grant) begin
               bus_addr = spr_addr;
               bus_rd   = spr_rd;
               bus_src  = SRC_SPRITE;
            end else if (smp_grant) begin
               bus_addr = smp_addr;
               bus_rd   = smp_rd;
               bus_src  = SRC_SAMPLE;
            end else begin
               bus_addr = core_addr;
               bus_rd   = core_rd;
               bus_src  = SRC_CORE;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/brd_sel_decode.sv
// Window check on the core address, register select from the bus address.
module brd_sel_decode #(
   parameter int            AW         = 16,
   parameter int            SW         = 5,
   parameter logic [AW-1:0] REG_BASE   = 16'h4000,
   parameter logic [SW-1:0] STATUS_SEL = 5'h15,
   parameter logic [SW-1:0] PAD0_SEL   = 5'h16,
   parameter logic [SW-1:0] PAD1_SEL   = 5'h17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] core_addr,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   input  logic          test_pin,
   output logic          in_window,
   output logic          pad0,
   output logic          pad1,
   output logic          isolate,
   output logic          status_hit
);
   localparam int HW = AW - SW;

   logic [SW-1:0] sel;
   logic          live;

   assign in_window  = (core_addr[AW-1:SW] == REG_BASE[AW-1:SW]);
   assign sel        = bus_addr[SW-1:0];
   assign live       = bus_rd & in_window;
   assign pad0       = live & (sel == PAD0_SEL);
   assign pad1       = live & (sel == PAD1_SEL);
   assign status_hit = live & (sel == STATUS_SEL);
   assign isolate    = live & (test_pin | (sel == STATUS_SEL));

   initial begin
      assert (HW > 0) else $error("window field must be non-empty");
   end

   assert_pads_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pad0, pad1}));

   assert_pad_needs_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pad0 || pad1 || isolate) |-> bus_rd);

   assert_test_isolates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && test_pin && core_addr[AW-1:SW] == REG_BASE[AW-1:SW]) |-> isolate);
endmodule

// File: rtl/brd_data_path.sv
// Internal data selection and external open-bus latch.
module brd_data_path #(
   parameter int            DW        = 8,
   parameter logic [DW-1:0] TEST_FILL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_rd,
   input  logic          isolate,
   input  logic          status_hit,
   input  logic [DW-1:0] ext_data,
   input  logic [DW-1:0] status_data,
   output logic [DW-1:0] int_data,
   output logic [DW-1:0] openbus_q
);
   always_comb begin
      if (!isolate)        int_data = ext_data;
      else if (status_hit) int_data = status_data;
      else                 int_data = TEST_FILL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  openbus_q <= '0;
      else if (bus_rd && !isolate) openbus_q <= ext_data;
   end

   assert_openbus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      isolate |=> $stable(openbus_q));

   assert_openbus_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !isolate) |=> (openbus_q == $past(ext_data)));

   assert_status_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_hit |-> (int_data == status_data));
endmodule

// File: rtl/brd_read_decoder.sv
module brd_read_decoder #(
   parameter int            AW           = 16,
   parameter int            DW           = 8,
   parameter int            SW           = 5,
   parameter logic [AW-1:0] REG_BASE     = 16'h4000,
   parameter logic [SW-1:0] STATUS_SEL   = 5'h15,
   parameter logic [SW-1:0] PAD0_SEL     = 5'h16,
   parameter logic [SW-1:0] PAD1_SEL     = 5'h17,
   parameter logic [DW-1:0] TEST_FILL    = '0,
   parameter bit            SAMPLE_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] core_addr,
   input  logic          core_rd,
   input  logic [AW-1:0] spr_addr,
   input  logic          spr_rd,
   input  logic          spr_grant,
   input  logic [AW-1:0] smp_addr,
   input  logic          smp_rd,
   input  logic          smp_grant,
   input  logic          test_pin,
   input  logic [DW-1:0] ext_data,
   input  logic [DW-1:0] status_data,
   output logic [DW-1:0] int_data,
   output logic          pad_clk0,
   output logic          pad_clk1,
   output logic          isolate,
   output logic          conflict,
   output logic [DW-1:0] openbus_q
);
   logic [AW-1:0]  bus_addr;
   logic           bus_rd;
   brd_pkg::src_t  bus_src;
   logic           in_window;
   logic           status_hit;

   initial begin
      assert (SW < AW) else $error("select width must be below address width");
      assert (DW > 0) else $error("data width must be positive");
      assert (STATUS_SEL != PAD0_SEL && STATUS_SEL != PAD1_SEL && PAD0_SEL != PAD1_SEL)
         else $error("register selects must differ");
   end

   brd_addr_mux #(.AW(AW), .SAMPLE_FIRST(SAMPLE_FIRST)) u_mux (
      .core_addr(core_addr), .core_rd(core_rd),
      .spr_addr(spr_addr), .spr_rd(spr_rd), .spr_grant(spr_grant),
      .smp_addr(smp_addr), .smp_rd(smp_rd), .smp_grant(smp_grant),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_src(bus_src)
   );

   brd_sel_decode #(
      .AW(AW), .SW(SW), .REG_BASE(REG_BASE), .STATUS_SEL(STATUS_SEL),
      .PAD0_SEL(PAD0_SEL), .PAD1_SEL(PAD1_SEL)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .test_pin(test_pin), .in_window(in_window),
      .pad0(pad_clk0), .pad1(pad_clk1), .isolate(isolate), .status_hit(status_hit)
   );

   brd_data_path #(.DW(DW), .TEST_FILL(TEST_FILL)) u_data (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .isolate(isolate),
      .status_hit(status_hit), .ext_data(ext_data), .status_data(status_data),
      .int_data(int_data), .openbus_q(openbus_q)
   );

   assign conflict = (pad_clk0 | pad_clk1) & ~isolate;

   assert_conflict_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |-> (int_data == ext_data));

   assert_no_strobe_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_clk0 || pad_clk1 || isolate) |-> (core_addr[AW-1:SW] == REG_BASE[AW-1:SW]));

   assert_sample_owns_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (SAMPLE_FIRST && smp_grant) |-> (bus_src == brd_pkg::SRC_SAMPLE && bus_rd == smp_rd));

   assert_window_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (in_window == (core_addr[AW-1:SW] == REG_BASE[AW-1:SW])));
endmodule

// File: tb/brd_read_decoder_tb.sv
module brd_read_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] core_addr = '0, spr_addr = '0, smp_addr = '0;
   logic        core_rd = 1'b0, spr_rd = 1'b0, spr_grant = 1'b0;
   logic        smp_rd = 1'b0, smp_grant = 1'b0, test_pin = 1'b0;
   logic [7:0]  ext_data = '0, status_data = 8'hA5;
   logic [7:0]  int_data, openbus_q;
   logic        pad_clk0, pad_clk1, isolate, conflict;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   brd_read_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_rd(core_rd),
      .spr_addr(spr_addr), .spr_rd(spr_rd), .spr_grant(spr_grant),
      .smp_addr(smp_addr), .smp_rd(smp_rd), .smp_grant(smp_grant),
      .test_pin(test_pin), .ext_data(ext_data), .status_data(status_data),
      .int_data(int_data), .pad_clk0(pad_clk0), .pad_clk1(pad_clk1),
      .isolate(isolate), .conflict(conflict), .openbus_q(openbus_q)
   );

   task automatic chk(input string req, input string what, input logic [15:0] got,
                      input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic [15:0] ca, input logic cr,
                        input logic [15:0] sa, input logic sr, input logic sg,
                        input logic [15:0] ma, input logic mr, input logic mg,
                        input logic tp, input logic [7:0] ed);
      core_addr = ca; core_rd = cr;
      spr_addr = sa; spr_rd = sr; spr_grant = sg;
      smp_addr = ma; smp_rd = mr; smp_grant = mg;
      test_pin = tp; ext_data = ed;
      #2;
   endtask

   task automatic outs(input string req, input logic p0, input logic p1,
                       input logic iso, input logic cf, input logic [7:0] d);
      chk(req, "pad_clk0", {15'd0, pad_clk0}, {15'd0, p0});
      chk(req, "pad_clk1", {15'd0, pad_clk1}, {15'd0, p1});
      chk(req, "isolate", {15'd0, isolate}, {15'd0, iso});
      chk(req, "conflict", {15'd0, conflict}, {15'd0, cf});
      chk(req, "int_data", {8'd0, int_data}, {8'd0, d});
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic idle;
      drive(16'h0000, 0, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h00);
   endtask

   task automatic t_reset;
      idle();
      outs("R7", 0, 0, 0, 0, 8'h00);
      chk("R7", "openbus reset", {8'd0, openbus_q}, 16'h0000);
   endtask

   task automatic t_core_status;
      drive(16'h6000, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h3C);
      outs("R2", 0, 0, 0, 0, 8'h3C);
      tick();
      chk("R7", "openbus load", {8'd0, openbus_q}, 16'h003C);
      drive(16'h4015, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h77);
      outs("R5", 0, 0, 1, 0, 8'hA5);
      tick();
      chk("R8", "openbus held", {8'd0, openbus_q}, 16'h003C);
   endtask

   task automatic t_core_pads;
      drive(16'h4016, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h41);
      outs("R4", 1, 0, 0, 1, 8'h41);
      chk("R9", "conflict", {15'd0, conflict}, 16'h0001);
      tick();
      chk("R7", "openbus after pad read", {8'd0, openbus_q}, 16'h0041);
      drive(16'h4017, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h42);
      outs("R4", 0, 1, 0, 1, 8'h42);
      idle();
      outs("R4", 0, 0, 0, 0, 8'h00);
   endtask

   task automatic t_window_edges;
      drive(16'h4020, 1, 16'h0, 0, 0, 16'h0, 0, 0, 1, 8'h55);
      outs("R2", 0, 0, 0, 0, 8'h55);
      drive(16'h4036, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h56);
      outs("R2", 0, 0, 0, 0, 8'h56);
      drive(16'h401F, 1, 16'h0, 0, 0, 16'h0, 0, 0, 0, 8'h57);
      outs("R2", 0, 0, 0, 0, 8'h57);
      tick();
      chk("R7", "openbus at 401F", {8'd0, openbus_q}, 16'h0057);
   endtask

   task automatic t_dma_outside;
      drive(16'h8123, 1, 16'h4016, 1, 1, 16'h0, 0, 0, 0, 8'h61);
      outs("R2", 0, 0, 0, 0, 8'h61);
      drive(16'hC000, 1, 16'h0, 0, 0, 16'h4015, 1, 1, 0, 8'h62);
      outs("R2", 0, 0, 0, 0, 8'h62);
   endtask

   task automatic t_dma_inside;
      drive(16'h4000, 1, 16'h4015, 1, 1, 16'h0, 0, 0, 0, 8'h71);
      outs("R10", 0, 0, 1, 0, 8'hA5);
      tick();
      chk("R8", "openbus after dma status", {8'd0, openbus_q}, 16'h0057);
      drive(16'h4016, 1, 16'h0, 0, 0, 16'hC0F7, 1, 1, 0, 8'h72);
      outs("R3", 0, 1, 0, 1, 8'h72);
      drive(16'h4015, 1, 16'h0, 0, 0, 16'h40F6, 1, 1, 0, 8'h73);
      outs("R3", 1, 0, 0, 1, 8'h73);
   endtask

   task automatic t_priority;
      drive(16'h4000, 1, 16'h4016, 1, 1, 16'h4017, 1, 1, 0, 8'h81);
      outs("R1", 0, 1, 0, 1, 8'h81);
      drive(16'h4000, 1, 16'h4016, 1, 1, 16'h4017, 0, 1, 0, 8'h82);
      outs("R1", 0, 0, 0, 0, 8'h82);
      drive(16'h4016, 1, 16'h4017, 0, 0, 16'h4015, 1, 0, 0, 8'h83);
      outs("R1", 1, 0, 0, 1, 8'h83);
   endtask

   task automatic t_test_pin;
      drive(16'h4003, 1, 16'h0, 0, 0, 16'h0, 0, 0, 1, 8'h91);
      outs("R6", 0, 0, 1, 0, 8'h00);
      drive(16'h4015, 1, 16'h0, 0, 0, 16'h0, 0, 0, 1, 8'h92);
      outs("R6", 0, 0, 1, 0, 8'hA5);
      drive(16'h4016, 1, 16'h0, 0, 0, 16'h0, 0, 0, 1, 8'h93);
      outs("R9", 1, 0, 1, 0, 8'h00);
      tick();
      chk("R8", "openbus after test read", {8'd0, openbus_q}, 16'h0083);
   endtask

   task automatic t_no_read;
      drive(16'h4016, 0, 16'h0, 0, 0, 16'h0, 0, 0, 1, 8'hB1);
      outs("R11", 0, 0, 0, 0, 8'hB1);
      tick();
      chk("R11", "openbus without read", {8'd0, openbus_q}, 16'h0083);
      drive(16'h4000, 1, 16'h4015, 0, 1, 16'h0, 0, 0, 0, 8'hB2);
      outs("R11", 0, 0, 0, 0, 8'hB2);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not end");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();
      t_reset();
      t_core_status();
      t_core_pads();
      t_window_edges();
      t_dma_outside();
      t_dma_inside();
      // openbus: last non-isolated read edge in t_dma_inside loaded nothing (no tick);
      // t_priority ends with a non-isolated core read, then one edge loads 0x83
      t_priority();
      tick();
      chk("R7", "openbus after priority", {8'd0, openbus_q}, 16'h0083);
      t_test_pin();
      t_no_read();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule